// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

The block watches a parameterised set of asynchronous event lines and turns selected transitions into interrupts. Each line is brought into the system clock domain through a two-flop synchronizer. The synchronized value is compared with its value one clock earlier, which yields a rising or falling transition. Software picks, per line, which transition direction counts. A counted transition latches a sticky pending flag for that line. If the line's interrupt-mask bit is set, the transition also produces a one-clock pulse on that line's own interrupt output.

Software reaches six 32-bit registers through a word-wide register bus. Writes take effect on the clock edge, and read data is combinational from the address. The address is a word index into a 1 KiB window (256 words). Index 0 holds the interrupt mask, 1 the event mask, 2 the rising select, 3 the falling select, 4 the software trigger and 5 the pending flags. Pending flags are cleared by writing ones to them. The event-mask and software-trigger registers are storage only. Bits at or above the line count read as zero.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, all six registers read 0 and every interrupt output is 0.
- R2: A write to word 0, 1, 2, 3 or 4 replaces the stored value with the written data. A later read of that word returns it, with bits at or above NUM_LINES reading 0.
- R3: A 0-to-1 change on line n, held long enough to be synchronized, sets pending bit n (word 5) when bit n of word 2 is 1. It leaves pending bit n unchanged when bit n of word 2 is 0. Pending becomes visible three clock edges after the input changes.
- R4: A 1-to-0 change on line n sets pending bit n when bit n of word 3 is 1. It leaves pending bit n unchanged when that bit is 0.
- R5: A selected edge sets the pending bit whatever the value of mask bit n (word 0). When the mask bit is 1, interrupt output n goes high for exactly one clock, in the same cycle that the pending bit appears.
- R6: A write to word 5 clears each pending bit written as 1 and leaves bits written as 0 unchanged. Pending bits otherwise stay set.
- R7: When a selected edge and a write-one-to-clear hit the same pending bit in the same cycle, the bit ends up set.
- R8: Reads of word indices 6 to 255 return 0. Writes to those indices change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_in | input | NUM_LINES | Asynchronous external event lines |
| reg_addr | input | 8 | Word index into the register window |
| reg_wen | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_out | output | NUM_LINES | Per-line interrupt pulses |

## Verification
The assertions take for granted that reg_addr, reg_wen and reg_wdata are stable around the rising clock edge. They make no assumption about ev_in, because the synchronizer absorbs its timing. The stimulus changes every input only at the falling clock edge. Each event level is held for at least one full clock, so every change passes through both synchronizer stages.

Random phases toggle lines and issue writes on arbitrary cycles. This covers edges that land on the same cycle as a clear, and mask changes that land on the same cycle as an edge.

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int NUM_LINES = 16,
  parameter int WIN_BYTES = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] ev_in,
  input  logic [7:0]           reg_addr,
  input  logic                 reg_wen,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [NUM_LINES-1:0] irq_out
);
  localparam int WORDS = WIN_BYTES / 4;
  localparam logic [7:0] A_MASK  = 8'd0;
  localparam logic [7:0] A_EVM   = 8'd1;
  localparam logic [7:0] A_RISE  = 8'd2;
  localparam logic [7:0] A_FALL  = 8'd3;
  localparam logic [7:0] A_SWT   = 8'd4;
  localparam logic [7:0] A_PEND  = 8'd5;
  localparam logic [31:0] LINE_BITS = 32'((64'd1 << NUM_LINES) - 64'd1);

  logic [NUM_LINES-1:0] mask_r, evm_r, rise_r, fall_r, swt_r, pend_r;
  logic [NUM_LINES-1:0] sync_a, sync_b, prev_r;
  logic [NUM_LINES-1:0] wd, clr, hit;
  logic unused_wbits;

  assign wd  = reg_wdata[NUM_LINES-1:0];
  assign unused_wbits = |(reg_wdata & ~LINE_BITS) | (WORDS == 0);
  assign clr = (reg_wen && reg_addr == A_PEND) ? wd : '0;
  assign hit = (sync_b & ~prev_r & rise_r) | (~sync_b & prev_r & fall_r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      prev_r <= '0;
    end else begin
      sync_a <= ev_in;
      sync_b <= sync_a;
      prev_r <= sync_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_r <= '0;
      evm_r  <= '0;
      rise_r <= '0;
      fall_r <= '0;
      swt_r  <= '0;
    end else if (reg_wen) begin
      case (reg_addr)
        A_MASK: mask_r <= wd;
        A_EVM:  evm_r  <= wd;
        A_RISE: rise_r <= wd;
        A_FALL: fall_r <= wd;
        A_SWT:  swt_r  <= wd;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_r  <= '0;
      irq_out <= '0;
    end else begin
      pend_r  <= (pend_r & ~clr) | hit;
      irq_out <= hit & mask_r;
    end
  end

  always_comb begin
    case (reg_addr)
      A_MASK:  reg_rdata = 32'(mask_r);
      A_EVM:   reg_rdata = 32'(evm_r);
      A_RISE:  reg_rdata = 32'(rise_r);
      A_FALL:  reg_rdata = 32'(fall_r);
      A_SWT:   reg_rdata = 32'(swt_r);
      A_PEND:  reg_rdata = 32'(pend_r);
      default: reg_rdata = 32'd0;
    endcase
  end

  // R3 and R4: a selected edge always lands in pending
  p_edge_sets_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hit) & ~pend_r) == '0);
  p_pending_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend_r) & ~$past(clr) & ~pend_r) == '0);
  p_clear_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr) & ~$past(hit) & pend_r) == '0);
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr) & $past(hit) & ~pend_r) == '0);
  p_irq_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & ~$past(mask_r)) == '0);
  p_irq_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & ~pend_r) == '0);
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > A_PEND) |-> (reg_rdata == 32'd0));
endmodule

// File: tb/edge_irq_ctrl_test.sv
module edge_irq_ctrl_test;
  localparam int N = 16;
  localparam int PERIOD = 10;
  localparam int LIMIT = 100000;
  localparam logic [31:0] LM = 32'h0000_FFFF;

  logic clk = 0, rst_n = 0, reg_wen = 0;
  logic [N-1:0] ev_in = '0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [N-1:0] irq_out;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  edge_irq_ctrl #(.NUM_LINES(N)) uut (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .reg_addr(reg_addr),
    .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out));

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [31:0] m_reg [6];
  logic [31:0] h1, h2, h3, m_hit, m_irq;
  initial begin
    for (int i = 0; i < 6; i++) m_reg[i] = 0;
    h1 = 0; h2 = 0; h3 = 0; m_irq = 0; m_hit = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) m_reg[i] = 0;
      h1 = 0; h2 = 0; h3 = 0; m_irq = 0;
    end else begin
      m_hit = ((h2 & ~h3) & m_reg[2]) | ((~h2 & h3) & m_reg[3]);
      m_irq = m_hit & m_reg[0];
      h3 = h2; h2 = h1; h1 = 32'(ev_in);
      if (reg_wen) begin
        if (reg_addr < 5) m_reg[reg_addr] = reg_wdata & LM;
        else if (reg_addr == 5) m_reg[5] = m_reg[5] & ~reg_wdata;
      end
      m_reg[5] = m_reg[5] | m_hit;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison against the reference, each cycle
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(32'(irq_out) == m_irq, "R5 irq_out vs model", 32'(irq_out), m_irq);
      chk(reg_rdata == ((reg_addr < 6) ? m_reg[reg_addr] : 32'd0),
          "R2/R8 rdata vs model", reg_rdata, (reg_addr < 6) ? m_reg[reg_addr] : 32'd0);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wen = 1;
    @(negedge clk); reg_wen = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_addr = a; #2;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic finish_run;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
      finish_run();
    end
  end

  int pulses;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    chk(irq_out == '0, "R1 irq after reset", 32'(irq_out), 0);
    for (int a = 0; a < 6; a++) rd_chk(8'(a), 0, "R1 reset value");

    wr(1, 32'hFFFF_FFFF); rd_chk(1, 32'h0000_FFFF, "R2 event mask upper bits");
    wr(4, 32'h0000_1234); rd_chk(4, 32'h0000_1234, "R2 software trigger");
    wr(0, 32'h0000_0001); rd_chk(0, 32'h0000_0001, "R2 interrupt mask");
    wr(2, 32'h0000_0003); rd_chk(2, 32'h0000_0003, "R2 rising select");
    wr(3, 32'h0000_0100); rd_chk(3, 32'h0000_0100, "R2 falling select");

    // R3 + R5: rising edge on line 0, unmasked, exact timing
    @(negedge clk); ev_in[0] = 1; pulses = 0;
    @(negedge clk); @(negedge clk); #2;
    chk(irq_out[0] == 0, "R5 no pulse before third edge", 32'(irq_out), 0);
    @(negedge clk); #2;
    chk(irq_out[0] == 1, "R5 pulse on third edge", 32'(irq_out), 1);
    rd_chk(5, 32'h0000_0001, "R3 pending after rising edge");
    chk(irq_out[0] == 0, "R5 pulse lasts one cycle", 32'(irq_out), 0);

    // R3: line 2 rising with select 0 -> no pending
    @(negedge clk); ev_in[2] = 1;
    repeat (4) @(negedge clk);
    rd_chk(5, 32'h0000_0001, "R3 unselected rising ignored");

    // R4 + R5: falling on line 8, masked -> pending but no pulse
    @(negedge clk); ev_in[8] = 1;
    repeat (4) @(negedge clk);
    rd_chk(5, 32'h0000_0001, "R4 rising on fall-only line ignored");
    @(negedge clk); ev_in[8] = 0;
    repeat (4) @(negedge clk);
    rd_chk(5, 32'h0000_0101, "R4/R5 falling sets pending while masked");
    chk(irq_out == '0, "R5 masked line gives no pulse", 32'(irq_out), 0);

    // R6: clear line 0 only
    wr(5, 32'h0000_0001);
    rd_chk(5, 32'h0000_0100, "R6 write-one-to-clear");
    wr(5, 32'h0000_0000);
    rd_chk(5, 32'h0000_0100, "R6 zero write keeps bits");

    // R7: edge on line 1 and clear of line 1 in the same cycle
    @(negedge clk); ev_in[1] = 1;
    @(negedge clk);
    @(negedge clk); reg_addr = 5; reg_wdata = 32'h0000_0002; reg_wen = 1;
    @(negedge clk); reg_wen = 0;
    rd_chk(5, 32'h0000_0102, "R7 set wins over clear");

    // R8: unmapped accesses
    wr(6, 32'hFFFF_FFFF);
    wr(8'd200, 32'hFFFF_FFFF);
    rd_chk(6, 0, "R8 unmapped read idx 6");
    rd_chk(8'd255, 0, "R8 unmapped read idx 255");
    rd_chk(0, 32'h0000_0001, "R8 mask unchanged");
    rd_chk(2, 32'h0000_0003, "R8 rising unchanged");
    rd_chk(5, 32'h0000_0102, "R8 pending unchanged");

    // random phase compared against the reference each cycle
    wr(0, 32'h0000_F0F0); wr(2, 32'h0000_FF00); wr(3, 32'h0000_0FF0);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) ev_in = N'($urandom);
      reg_addr = 8'($urandom_range(0, 7));
      reg_wen = ($urandom_range(0, 5) == 0);
      reg_wdata = $urandom;
    end
    @(negedge clk); reg_wen = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule